// File: doc/BRIEF.md
# Two-Wire Switch Register Reader

This block is a master for a two-wire management link made of a clock line and one bidirectional data line. It reads 16-bit registers from a switch device. The host raises a one-cycle read strobe with a register address and a command byte. The block then frames the whole transaction on the link, turns the data line around and collects the reply. When the reply is complete it returns it with a single-cycle done pulse.

The link clock comes from the system clock through a divider whose half-period is set by a parameter. Data only changes while the link clock is low. Address and data travel as bytes, low byte first, and each byte is sent most significant bit first. The data line is modelled as three plain ports (output value, output enable and input value), so a pad cell outside the block forms the actual tristate.

Top module: `mgmt2w_reader`

## Requirements
- R1: An accepted read begins with exactly three driven data bits of value 1, 0, 1 on the first three rising link-clock edges, with no preamble before them.
- R2: The next 8 driven bits are the command byte, most significant bit first, taken from `rd_cmd` as it was on the cycle the request was accepted.
- R3: The next 16 driven bits are the address: bits 7..0 first, then bits 15..8, each byte most significant bit first. The address is taken on the cycle the request was accepted.
- R4: After the address, `md_oe` stays low for 17 clock pulses: one idle turnaround pulse, then the 16 data pulses.
- R5: `md_in` is sampled at the end of each high phase of the 16 data pulses. The first 8 samples form `rd_data[7:0]` and the next 8 form `rd_data[15:8]`, each byte most significant bit first.
- R6: After the data, the block drives 0 and then 1 (the stop pattern), then one extra pulse with the line driven 1. A frame has exactly 47 rising link-clock edges.
- R7: Each high phase of `mdc` lasts exactly HALF_DIV system clocks. `md_out` and `md_oe` never change while `mdc` is high.
- R8: `busy` rises on the cycle after a request is accepted and stays high until `done`. A request raised while `busy` is high starts no new frame and produces no extra `done`.
- R9: `done` is high for exactly one cycle, 94*HALF_DIV cycles after the accepting edge, with `rd_data` valid on that cycle and `busy` low.
- R10: After reset, including a reset in the middle of a frame, `mdc`, `md_oe`, `busy`, `done` and `rd_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req | input | 1 | Read strobe, accepted when `busy` is low |
| rd_addr | input | 16 | Register address |
| rd_cmd | input | 8 | Command byte sent after the start pattern (0xA9 on common parts) |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Assembled read value |
| mdc | output | 1 | Management clock |
| md_out | output | 1 | Data line output value |
| md_oe | output | 1 | Data line output enable |
| md_in | input | 1 | Data line input value |

## Verification
Counted from the edge that accepts the request, `busy` is due on the following cycle. The done pulse and `rd_data` are due exactly 94*HALF_DIV edges later, and `done` must be low again one cycle after that. Each driven bit must be stable at the rising edge of `mdc`, and each reply bit is sampled on the falling edge that ends its high phase. The bench therefore samples everything on the falling system-clock edge. It counts falling edges from the request to done and compares that count with the exact latency. It logs line values at each detected `mdc` rise and checks the frame against the logs after the pulse. The bench's reply model updates `md_in` only on falling system-clock edges, so the design's sampling edge always sees a settled value.

// File: rtl/mgmt2w_pkg.sv
package mgmt2w_pkg;

   // Fixed framing lengths of the link protocol, in clock pulses
   localparam int unsigned START_LEN = 3;
   localparam int unsigned TURN_LEN  = 1;
   localparam int unsigned STOP_LEN  = 2;
   localparam int unsigned TRAIL_LEN = 1;

   // Start pattern, oldest bit in the MSB
   localparam logic [START_LEN-1:0] START_PAT = 3'b101;

   typedef enum logic [2:0] {
      SEG_IDLE,
      SEG_START,
      SEG_CMD,
      SEG_ADDR,
      SEG_TURN,
      SEG_DATA,
      SEG_STOP,
      SEG_TRAIL
   } seg_t;

   // Bit position of the j-th wire bit of a little-endian word whose bytes
   // are each sent most significant bit first
   function automatic int unsigned wire_to_word(input int unsigned j);
      return (j / 8) * 8 + 7 - (j % 8);
   endfunction

   function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                        input int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/mgmt2w_clkgen.sv
module mgmt2w_clkgen #(
   parameter int unsigned HALF_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic mdc,
   output logic slot_end
);

   generate
      if (HALF_DIV == 1) begin : g_fast
         // One system clock per phase: toggle every running cycle
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               mdc <= 1'b0;
            end else if (!run) begin
               mdc <= 1'b0;
            end else begin
               mdc <= ~mdc;
            end
         end
         assign slot_end = run & mdc;
      end else begin : g_div
         localparam int unsigned HCW = $clog2(HALF_DIV);
         localparam logic [HCW-1:0] HLAST = HCW'(HALF_DIV - 1);
         logic [HCW-1:0] hcnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hcnt <= '0;
               mdc  <= 1'b0;
            end else if (!run) begin
               hcnt <= '0;
               mdc  <= 1'b0;
            end else if (hcnt == HLAST) begin
               hcnt <= '0;
               mdc  <= ~mdc;
            end else begin
               hcnt <= hcnt + 1'b1;
            end
         end
         assign slot_end = run & mdc & (hcnt == HLAST);
      end
   endgenerate

endmodule

// File: rtl/mgmt2w_seq.sv
module mgmt2w_seq
   import mgmt2w_pkg::*;
#(
   parameter int unsigned CMD_W  = 8,
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_req,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [CMD_W-1:0]  rd_cmd,
   input  logic              slot_end,
   output logic              busy,
   output logic              done,
   output logic              md_out,
   output logic              md_oe,
   output logic              rx_en,
   output logic              rx_last
);

   localparam int unsigned TX_W   = START_LEN + CMD_W + ADDR_W;
   localparam int unsigned MAXLEN = max3(CMD_W, ADDR_W, DATA_W);
   localparam int unsigned BCW    = $clog2(MAXLEN);

   localparam logic [BCW-1:0] LAST_START = BCW'(START_LEN - 1);
   localparam logic [BCW-1:0] LAST_CMD   = BCW'(CMD_W - 1);
   localparam logic [BCW-1:0] LAST_ADDR  = BCW'(ADDR_W - 1);
   localparam logic [BCW-1:0] LAST_TURN  = BCW'(TURN_LEN - 1);
   localparam logic [BCW-1:0] LAST_DATA  = BCW'(DATA_W - 1);
   localparam logic [BCW-1:0] LAST_STOP  = BCW'(STOP_LEN - 1);
   localparam logic [BCW-1:0] LAST_TRAIL = BCW'(TRAIL_LEN - 1);

   seg_t              seg, seg_nxt;
   logic [BCW-1:0]    bcnt;
   logic [BCW-1:0]    seg_last;
   logic [TX_W-1:0]   tx_sr;
   logic [ADDR_W-1:0] addr_wire;
   logic              accept;
   logic              seg_done;

   // Reorder the address so that a plain left shift emits wire order
   for (genvar j = 0; j < ADDR_W; j++) begin : g_addr_ord
      assign addr_wire[ADDR_W-1-j] = rd_addr[wire_to_word(j)];
   end

   assign accept = rd_req & (seg == SEG_IDLE);
   assign busy   = (seg != SEG_IDLE);

   always_comb begin
      case (seg)
         SEG_START: seg_last = LAST_START;
         SEG_CMD:   seg_last = LAST_CMD;
         SEG_ADDR:  seg_last = LAST_ADDR;
         SEG_TURN:  seg_last = LAST_TURN;
         SEG_DATA:  seg_last = LAST_DATA;
         SEG_STOP:  seg_last = LAST_STOP;
         SEG_TRAIL: seg_last = LAST_TRAIL;
         default:   seg_last = '0;
      endcase
   end

   always_comb begin
      case (seg)
         SEG_START: seg_nxt = SEG_CMD;
         SEG_CMD:   seg_nxt = SEG_ADDR;
         SEG_ADDR:  seg_nxt = SEG_TURN;
         SEG_TURN:  seg_nxt = SEG_DATA;
         SEG_DATA:  seg_nxt = SEG_STOP;
         SEG_STOP:  seg_nxt = SEG_TRAIL;
         default:   seg_nxt = SEG_IDLE;
      endcase
   end

   assign seg_done = slot_end & (bcnt == seg_last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seg   <= SEG_IDLE;
         bcnt  <= '0;
         tx_sr <= '0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (accept) begin
            seg   <= SEG_START;
            bcnt  <= '0;
            tx_sr <= {START_PAT, rd_cmd, addr_wire};
         end else if (slot_end) begin
            tx_sr <= {tx_sr[TX_W-2:0], 1'b0};
            if (seg_done) begin
               seg  <= seg_nxt;
               bcnt <= '0;
               if (seg == SEG_TRAIL) begin
                  done <= 1'b1;
               end
            end else begin
               bcnt <= bcnt + 1'b1;
            end
         end
      end
   end

   // Line drive: registers only change at slot ends, i.e. on falling mdc
   always_comb begin
      case (seg)
         SEG_START, SEG_CMD, SEG_ADDR: begin
            md_out = tx_sr[TX_W-1];
            md_oe  = 1'b1;
         end
         SEG_STOP: begin
            md_out = (bcnt != '0);
            md_oe  = 1'b1;
         end
         SEG_TRAIL: begin
            md_out = 1'b1;
            md_oe  = 1'b1;
         end
         default: begin
            md_out = 1'b0;
            md_oe  = 1'b0;
         end
      endcase
   end

   assign rx_en   = slot_end & (seg == SEG_DATA);
   assign rx_last = slot_end & (seg == SEG_TRAIL);

endmodule

// File: rtl/mgmt2w_rx.sv
module mgmt2w_rx
   import mgmt2w_pkg::*;
#(
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_en,
   input  logic              rx_last,
   input  logic              md_in,
   output logic [DATA_W-1:0] rd_data
);

   logic [DATA_W-1:0] rx_sr;
   logic [DATA_W-1:0] rx_word;

   // First wire bit ends up in rx_sr MSB; map wire order to word order
   for (genvar j = 0; j < DATA_W; j++) begin : g_data_ord
      assign rx_word[wire_to_word(j)] = rx_sr[DATA_W-1-j];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_sr   <= '0;
         rd_data <= '0;
      end else begin
         if (rx_en) begin
            rx_sr <= {rx_sr[DATA_W-2:0], md_in};
         end
         if (rx_last) begin
            rd_data <= rx_word;
         end
      end
   end

endmodule

// File: rtl/mgmt2w_reader.sv
module mgmt2w_reader #(
   parameter int unsigned HALF_DIV = 4,
   parameter int unsigned CMD_W    = 8,
   parameter int unsigned ADDR_W   = 16,
   parameter int unsigned DATA_W   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_req,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [CMD_W-1:0]  rd_cmd,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rd_data,
   output logic              mdc,
   output logic              md_out,
   output logic              md_oe,
   input  logic              md_in
);

   // Elaboration-time parameter checks
   if (HALF_DIV < 1) begin : g_bad_div
      $error("HALF_DIV must be at least 1");
   end
   if ((CMD_W == 0) || (CMD_W % 8 != 0)) begin : g_bad_cmd
      $error("CMD_W must be a nonzero multiple of 8");
   end
   if ((ADDR_W == 0) || (ADDR_W % 8 != 0)) begin : g_bad_addr
      $error("ADDR_W must be a nonzero multiple of 8");
   end
   if ((DATA_W == 0) || (DATA_W % 8 != 0)) begin : g_bad_data
      $error("DATA_W must be a nonzero multiple of 8");
   end

   logic slot_end;
   logic rx_en;
   logic rx_last;

   mgmt2w_clkgen #(
      .HALF_DIV(HALF_DIV)
   ) u_clkgen (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (busy),
      .mdc      (mdc),
      .slot_end (slot_end)
   );

   mgmt2w_seq #(
      .CMD_W  (CMD_W),
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_req   (rd_req),
      .rd_addr  (rd_addr),
      .rd_cmd   (rd_cmd),
      .slot_end (slot_end),
      .busy     (busy),
      .done     (done),
      .md_out   (md_out),
      .md_oe    (md_oe),
      .rx_en    (rx_en),
      .rx_last  (rx_last)
   );

   mgmt2w_rx #(
      .DATA_W (DATA_W)
   ) u_rx (
      .clk     (clk),
      .rst_n   (rst_n),
      .rx_en   (rx_en),
      .rx_last (rx_last),
      .md_in   (md_in),
      .rd_data (rd_data)
   );

endmodule

// File: rtl/mgmt2w_reader_chk.sv
module mgmt2w_reader_chk #(
   parameter int unsigned HALF_DIV = 4
) (
   input logic clk,
   input logic rst_n,
   input logic busy,
   input logic done,
   input logic mdc,
   input logic md_out,
   input logic md_oe
);

   logic        mdc_d;
   int unsigned run_q;

   // Length of the mdc level that ended on the previous cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mdc_d <= 1'b0;
         run_q <= 0;
      end else begin
         mdc_d <= mdc;
         if (mdc != mdc_d) begin
            run_q <= 1;
         end else if (run_q < 32'hFFFF_FFFF) begin
            run_q <= run_q + 1;
         end
      end
   end

   AST_HIGH_PHASE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      (mdc_d && !mdc) |-> (run_q == HALF_DIV)); // R7

   AST_LINE_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (mdc && mdc_d) |-> ($stable(md_out) && $stable(md_oe))); // R7

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R9

   AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R9

   AST_BUSY_ENDS_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done); // R8

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mdc && !md_oe)); // R10

endmodule

bind mgmt2w_reader mgmt2w_reader_chk #(
   .HALF_DIV(HALF_DIV)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .busy   (busy),
   .done   (done),
   .mdc    (mdc),
   .md_out (md_out),
   .md_oe  (md_oe)
);

// File: tb/tb_mgmt2w_reader.sv
`timescale 1ns/1ps
module tb_mgmt2w_reader;

   localparam int unsigned HALF  = 3;
   localparam int          FRAME = 47;
   localparam int          LAT   = 94 * HALF + 1;   // falling edges from request to done
   localparam int          NVEC  = 5;

   // {cmd, addr, reply}
   localparam logic [39:0] VEC [NVEC] = '{
      {8'hA9, 16'h1234, 16'hBEEF},
      {8'hA9, 16'h0000, 16'hFFFF},
      {8'h5C, 16'hFFFF, 16'h0001},
      {8'hA9, 16'h80FE, 16'h8000},
      {8'h3F, 16'h00C1, 16'h5AA5}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rd_req = 1'b0;
   logic [15:0] rd_addr = '0;
   logic [7:0]  rd_cmd = '0;
   logic        busy, done, mdc, md_out, md_oe, md_in;
   logic [15:0] rd_data;
   logic [15:0] reply = '0;

   int checks = 0;
   int fails  = 0;

   // monitor state
   int  rise_cnt = 0;
   int  hi_len = 0;
   int  bad_hi = 0;
   int  bad_stable = 0;
   int  done_cnt = 0;
   logic mdc_q = 1'b0, mdo_q = 1'b0, oe_q = 1'b0, busy_q = 1'b0;
   bit  log_oe [64];
   bit  log_d  [64];

   always #5 clk = ~clk;

   mgmt2w_reader #(.HALF_DIV(HALF)) dut (
      .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr), .rd_cmd(rd_cmd),
      .busy(busy), .done(done), .rd_data(rd_data), .mdc(mdc), .md_out(md_out),
      .md_oe(md_oe), .md_in(md_in)
   );

   function automatic int w2b(input int j);
      return (j / 8) * 8 + 7 - (j % 8);
   endfunction

   // Reply model: bit for pulse index rise_cnt-1, valid while mdc is high
   function automatic logic reply_bit(input int rc, input logic [15:0] r);
      int j;
      j = rc - 1 - 28;
      if (j >= 0 && j < 16) return r[w2b(j)];
      return 1'b0;
   endfunction
   assign md_in = reply_bit(rise_cnt, reply);

   function automatic bit exp_tx(input int s, input logic [7:0] c, input logic [15:0] a);
      if (s < 3)  return (s != 1);
      if (s < 11) return c[7 - (s - 3)];
      if (s < 27) return a[w2b(s - 11)];
      if (s == 44) return 1'b0;
      return 1'b1;
   endfunction

   always @(negedge clk) begin
      if (busy && !busy_q) begin
         rise_cnt   = 0;
         bad_hi     = 0;
         bad_stable = 0;
         done_cnt   = 0;
      end
      if (mdc && !mdc_q) begin
         if (rise_cnt < 64) begin
            log_oe[rise_cnt] = md_oe;
            log_d[rise_cnt]  = md_out;
         end
         rise_cnt = rise_cnt + 1;
         hi_len   = 1;
      end else if (mdc) begin
         hi_len = hi_len + 1;
         if (md_out !== mdo_q || md_oe !== oe_q) bad_stable = bad_stable + 1;
      end
      if (!mdc && mdc_q && hi_len != int'(HALF)) bad_hi = bad_hi + 1;
      if (done) done_cnt = done_cnt + 1;
      mdc_q  = mdc;
      mdo_q  = md_out;
      oe_q   = md_oe;
      busy_q = busy;
   end

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic check_idle(input string tag);
      chk(mdc === 1'b0 && md_oe === 1'b0, {tag, " mdc/md_oe idle"}, {mdc, md_oe}, 0);
      chk(busy === 1'b0 && done === 1'b0, {tag, " busy/done idle"}, {busy, done}, 0);
      chk(rd_data === 16'h0, {tag, " rd_data cleared"}, rd_data, 0);
   endtask

   task automatic run_read(input logic [7:0] c, input logic [15:0] a,
                           input logic [15:0] r, input bit poke);
      int n;
      int bad;
      @(negedge clk);
      reply   = r;
      rd_cmd  = c;
      rd_addr = a;
      rd_req  = 1'b1;
      @(negedge clk);
      rd_req = 1'b0;
      n = 1;
      chk(busy === 1'b1, "R8 busy after accept", busy, 1);
      while (done !== 1'b1 && n < 4000) begin
         @(negedge clk);
         n++;
         // R8: a second request while busy must be ignored
         rd_req = poke && (n == 3);
         if (poke && n == 3) begin
            rd_addr = ~a;
            rd_cmd  = ~c;
         end
      end
      rd_req = 1'b0;
      chk(n == LAT, "R9 done latency", n, LAT);
      chk(rd_data === r, "R5 assembled read data", rd_data, r);
      chk(busy === 1'b0, "R9 busy low with done", busy, 0);
      @(negedge clk);
      chk(done === 1'b0, "R9 done one cycle", done, 0);
      repeat (4 * HALF) @(negedge clk);
      chk(done_cnt == 1 && busy === 1'b0, "R8 single done, no restart", done_cnt, 1);
      chk(rise_cnt == FRAME, "R6 pulse count", rise_cnt, FRAME);
      bad = 0;
      for (int s = 0; s < 3; s++) if (!log_oe[s] || log_d[s] != exp_tx(s, c, a)) bad++;
      chk(bad == 0, "R1 start pattern", bad, 0);
      bad = 0;
      for (int s = 3; s < 11; s++) if (!log_oe[s] || log_d[s] != exp_tx(s, c, a)) bad++;
      chk(bad == 0, "R2 command byte", bad, 0);
      bad = 0;
      for (int s = 11; s < 27; s++) if (!log_oe[s] || log_d[s] != exp_tx(s, c, a)) bad++;
      chk(bad == 0, "R3 address bytes", bad, 0);
      bad = 0;
      for (int s = 27; s < 44; s++) if (log_oe[s]) bad++;
      chk(bad == 0, "R4 released for turnaround and data", bad, 0);
      bad = 0;
      for (int s = 44; s < 47; s++) if (!log_oe[s] || log_d[s] != exp_tx(s, c, a)) bad++;
      chk(bad == 0, "R6 stop pattern and trailing pulse", bad, 0);
      chk(bad_hi == 0 && bad_stable == 0, "R7 high phase length and stability",
          bad_hi + bad_stable, 0);
   endtask

   // Watchdog
   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check_idle("R10 after reset");
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // Table-driven reads
      for (int i = 0; i < NVEC; i++) begin
         run_read(VEC[i][39:32], VEC[i][31:16], VEC[i][15:0], 1'b0);
      end

      // Directed: request while busy is ignored
      run_read(8'hA9, 16'h0F0F, 16'hC33C, 1'b1);

      // Directed: reset in the middle of a frame
      @(negedge clk);
      reply   = 16'h1111;
      rd_addr = 16'h2222;
      rd_cmd  = 8'hA9;
      rd_req  = 1'b1;
      @(negedge clk);
      rd_req = 1'b0;
      repeat (40 * HALF) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check_idle("R10 mid-frame reset");
      @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // Recovery after the aborted frame
      run_read(8'hA9, 16'h4321, 16'h6789, 1'b0);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule